// File: doc/BRIEF.md
# Lowest-Free Slot Allocator

This block tracks the occupancy of a large pool of slots with one bit per slot, where zero means free and one means taken. When a client raises the allocate strobe, the block finds the free slot with the smallest number. It claims that slot and returns its number in binary on the next clock. A client that is done with a slot returns it with the release strobe and the slot number, and that slot can then be handed out again.

The lowest free position is found by a radix-4 reduction tree rather than a linear priority chain. Each node of the tree looks at four children and records two things: whether any of them holds a free slot, and the partial position of the first one that does. The root's any-free bit comes straight from the OR of its four children, without waiting on the position multiplexers. The pool size is a parameter and must be a power of four: 1024 by default, with 4096 also supported.

Top module: `first_free_alloc`

## Requirements
- R1: While `rst` is high at a clock edge, every slot becomes free, and `slot_found`, `slot_idx` and `all_full` read zero after that edge.
- R2: When `alloc_req` is high at a clock edge and a free slot exists, `slot_found` is 1 after that edge and `slot_idx` holds the binary number of the lowest-numbered free slot.
- R3: A slot returned by an allocate is marked taken at the same edge and is not returned again until it is released, so back-to-back allocates from an empty pool yield 0, 1, 2 and so on.
- R4: An allocate while every slot is taken gives `slot_found` = 0 and `slot_idx` = 0, and leaves the occupancy unchanged (`all_full` stays 1).
- R5: When `rel_req` is high at an edge, the slot numbered `rel_idx` becomes free, and a later allocate can return it.
- R6: When release and allocate arrive at the same edge, the release is applied first, and the allocate searches the occupancy that includes it.
- R7: At an edge where `alloc_req` is low, `slot_found` and `slot_idx` become 0, and without a release the occupancy is unchanged.
- R8: `all_full` is 1 exactly when every slot is taken, as of the most recent clock edge.
- R9: Releasing a slot that is already free has no effect on the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Claim the lowest free slot at this edge |
| rel_req | input | 1 | Free the slot given by `rel_idx` at this edge |
| rel_idx | input | log2(SLOTS) | Number of the slot to free |
| slot_idx | output | log2(SLOTS) | Slot claimed by the previous allocate, 0 if none |
| slot_found | output | 1 | Previous allocate found a free slot |
| all_full | output | 1 | Every slot is currently taken |

## Verification
The bench fills the entire pool in order, so a tree that drops a position bit at some level returns repeated or skipped numbers as it crosses a group boundary. It then allocates into a full pool, where a design that writes a stale position or sets a bit anyway reports a false hit or leaves the full flag wrong. It also releases and allocates in the same cycle: a design that searches before applying the release misses the freed slot and returns a higher one. Finally, long random mixes of allocates and releases, including releases of slots that are already free, are compared against a loop-based model of the occupancy after every cycle.

// File: rtl/first_free_alloc.sv
module first_free_alloc #(
  parameter int SLOTS = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_req,
  input  logic                       rel_req,
  input  logic [$clog2(SLOTS)-1:0]   rel_idx,
  output logic [$clog2(SLOTS)-1:0]   slot_idx,
  output logic                       slot_found,
  output logic                       all_full
);
  localparam int IW     = $clog2(SLOTS);
  localparam int LEVELS = IW / 2;
  localparam int NODES  = (4 * SLOTS - 1) / 3;

  function automatic int level_base(input int lv);
    int b;
    b = 0;
    for (int k = 0; k < lv; k++) b += SLOTS >> (2 * k);
    return b;
  endfunction

  logic [SLOTS-1:0] occ_q, occ_rel, claim_mask;
  logic [NODES-1:0] any_free;
  logic [IW-1:0]    pos [NODES];
  logic             hit;
  logic [IW-1:0]    win;

  assign occ_rel = rel_req ? (occ_q & ~(SLOTS'(1) << rel_idx)) : occ_q;

  always_comb begin
    logic [3:0] kid;
    logic [1:0] pick;
    int         pb, cb;
    kid = '0;
    pick = '0;
    pb = 0;
    cb = 0;
    any_free = '0;
    for (int i = 0; i < NODES; i++) pos[i] = '0;
    for (int i = 0; i < SLOTS; i++) any_free[i] = ~occ_rel[i];
    for (int lv = 1; lv <= LEVELS; lv++) begin
      pb = level_base(lv - 1);
      cb = level_base(lv);
      for (int n = 0; n < (SLOTS >> (2 * lv)); n++) begin
        kid = any_free[pb + 4 * n +: 4];
        if (kid[0])      pick = 2'd0;
        else if (kid[1]) pick = 2'd1;
        else if (kid[2]) pick = 2'd2;
        else             pick = 2'd3;
        any_free[cb + n] = |kid;
        pos[cb + n] = pos[pb + 4 * n + int'(pick)] | (IW'(pick) << (2 * (lv - 1)));
      end
    end
  end

  assign hit        = any_free[NODES-1];
  assign win        = pos[NODES-1];
  assign claim_mask = (alloc_req && hit) ? (SLOTS'(1) << win) : '0;
  assign all_full   = &occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q      <= '0;
      slot_found <= 1'b0;
      slot_idx   <= '0;
    end else begin
      occ_q      <= occ_rel | claim_mask;
      slot_found <= alloc_req & hit;
      slot_idx   <= (alloc_req && hit) ? win : '0;
    end
  end
endmodule

module first_free_alloc_chk #(
  parameter int SLOTS = 1024
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     alloc_req,
  input logic                     rel_req,
  input logic [$clog2(SLOTS)-1:0] slot_idx,
  input logic                     slot_found,
  input logic                     all_full
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!slot_found && slot_idx == '0 && !all_full));

  assert_found_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    slot_found |-> $past(alloc_req));

  assert_full_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (all_full && alloc_req && !rel_req) |=> (!slot_found && slot_idx == '0 && all_full));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !alloc_req |=> (!slot_found && slot_idx == '0));

  assert_idle_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!alloc_req && !rel_req) |=> $stable(all_full));
endmodule

bind first_free_alloc first_free_alloc_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .rel_req(rel_req),
  .slot_idx(slot_idx), .slot_found(slot_found), .all_full(all_full)
);

// File: tb/tb_first_free_alloc.sv
`timescale 1ns/1ps
module tb_first_free_alloc;
  localparam int SLOTS = 1024;
  localparam int IW    = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_req = 1'b0, rel_req = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic [IW-1:0] slot_idx;
  logic slot_found, all_full;

  always #4 clk = ~clk;

  first_free_alloc #(.SLOTS(SLOTS)) dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rel_req(rel_req),
    .rel_idx(rel_idx), .slot_idx(slot_idx), .slot_found(slot_found),
    .all_full(all_full)
  );

  typedef struct {
    bit    found;
    int    idx;
    bit    full;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   model [SLOTS];
  int   total = 0, bad = 0;
  bit   finished = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit r, input int ri, input string tag);
    exp_t e;
    @(negedge clk);
    alloc_req = a;
    rel_req   = r;
    rel_idx   = IW'(ri);
    if (r) model[ri] = 1'b0;
    e.found = 1'b0;
    e.idx   = 0;
    if (a) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (!model[i]) begin
          e.found = 1'b1;
          e.idx   = i;
          model[i] = 1'b1;
          break;
        end
      end
    end
    e.full = 1'b1;
    for (int i = 0; i < SLOTS; i++) if (!model[i]) e.full = 1'b0;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "slot_found", int'(slot_found), int'(e.found));
        check(e.tag, "slot_idx", int'(slot_idx), e.idx);
        check({e.tag, "/R8"}, "all_full", int'(all_full), int'(e.full));
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "slot_found", int'(slot_found), 0);
    check("R1", "slot_idx", int'(slot_idx), 0);
    check("R1", "all_full", int'(all_full), 0);

    step(0, 0, 0, "R7");
    for (int i = 0; i < SLOTS; i++) step(1, 0, 0, "R3");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R4");
    step(0, 0, 0, "R7");
    step(0, 1, 500, "R5");
    step(1, 0, 0, "R5");
    step(0, 1, 3, "R5");
    step(0, 1, 900, "R5");
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R2");
    step(1, 1, 7, "R6");
    step(1, 1, 1023, "R6");
    step(0, 1, 12, "R9");
    step(0, 1, 12, "R9");
    step(0, 0, 0, "R7");
    step(1, 0, 0, "R9");
    step(1, 0, 0, "R4");

    for (int n = 0; n < 20000; n++) begin
      bit a, r;
      a = ($urandom_range(0, 99) < 55);
      r = ($urandom_range(0, 99) < 45);
      step(a, r, $urandom_range(0, SLOTS - 1), "R2");
    end
    for (int n = 0; n < 200; n++) step(0, 1, n * 5, "R9");
    for (int n = 0; n < 300; n++) step(1, 0, 0, "R3");

    @(negedge clk);
    alloc_req = 1'b0;
    rel_req   = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "slot_found", int'(slot_found), 0);
    check("R1", "all_full", int'(all_full), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule